// File: doc/BRIEF.md
# Quad-Pixel Raster Timing Generator

This block produces the data-enable raster for a 1920x1080 panel that is fed four pixels per clock over four parallel lanes. It counts pixel-group clocks across each line and lines down each frame. It raises a data-enable strobe over the active window and marks the first active group of every frame with a one-clock pulse. For each lane it reports which pixel of the line that lane carries, and it formats the colour words passed through each lane to the selected colour depth. Sync pulses play no part: the active region is defined by the enable strobe alone.

The active window is 480 groups by 1080 lines. Horizontal and vertical blanking come either from built-in defaults or from two configuration inputs. The vertical default depends on a refresh-class select, which picks between a 60/120 Hz class and a 50/100 Hz class. Programmed values are clamped to the allowed range and take effect only at a frame boundary. Serialisation, the electrical layer and the pixel content itself sit outside this block.

Top module: `qpix_raster_gen`

## Requirements
- R1: While `rst_n` is low, `de`, `frame_start`, `col`, `line`, every `lane_idx` field and every `lane_px_out` bit are 0. The first clock edge after release starts line 0 at group 0.
- R2: Each line is ACT_GROUPS active groups (default 480) followed by the effective horizontal blanking. `col` counts 0 up to ACT_GROUPS + hblank - 1, then returns to 0.
- R3: Each frame is ACT_LINES active lines (default 1080) followed by the effective vertical blanking. `line` advances when `col` wraps. `de` is 1 exactly when `col` < ACT_GROUPS and `line` < ACT_LINES.
- R4: With `blank_prog` = 0, horizontal blanking is 70 groups. Vertical blanking is 45 lines when `rate_slow` = 0 and 270 lines when `rate_slow` = 1.
- R5: With `blank_prog` = 1, horizontal blanking is `hblank_cfg` clamped to 40..200, and vertical blanking is `vblank_cfg` clamped to 20..300.
- R6: The blanking selection (`blank_prog`, `rate_slow`, `hblank_cfg`, `vblank_cfg`) is sampled only on the first edge after reset and on the edge that ends a frame. Changes at any other time affect only the next frame.
- R7: `frame_start` is a one-clock pulse, high exactly when `de` = 1, `col` = 0 and `line` = 0.
- R8: Lane p's field of `lane_idx` (bits p*IW upward) equals 4*`col` + p while `de` = 1, and 0 otherwise. So lane 0 carries pixel 4k, lane 1 carries 4k+1, lane 2 carries 4k+2 and lane 3 carries 4k+3.
- R9: Each lane word is three CW-bit colours, with colour c at bits lane*3*CW + c*CW. While `de` = 1, `lane_px_out` equals `lane_px_in` when `depth10` = 1. When `depth10` = 0, the two least significant bits of every colour are 0 and the upper 8 pass through unchanged. While `de` = 0, `lane_px_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-group clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_slow | input | 1 | 1 selects 50/100 Hz-class vertical blanking default |
| depth10 | input | 1 | 1 for 10-bit colours, 0 for 8-bit colours |
| blank_prog | input | 1 | 1 uses programmed blanking lengths |
| hblank_cfg | input | HBW | Programmed horizontal blanking in groups |
| vblank_cfg | input | VBW | Programmed vertical blanking in lines |
| lane_px_in | input | LANES*3*CW | Colour words, one pixel per lane |
| de | output | 1 | Data enable over the active window |
| frame_start | output | 1 | First active group of a frame |
| col | output | HW | Group counter within the line |
| line | output | VW | Line counter within the frame |
| lane_idx | output | LANES*IW | Pixel index carried by each lane |
| lane_px_out | output | LANES*3*CW | Depth-formatted colour words |

## Verification
A corrupted group or line counter shows up at `col`, `line` and `lane_idx` in the same cycle. A wrong wrap point shifts `de` and `frame_start` within one line or one frame. A wrongly latched blanking length stays hidden until the first blanking interval that uses it, then moves every later line or frame boundary. A depth-formatting fault is visible at `lane_px_out` on the first active group. The scoreboard compares every output against an independent per-cycle model, so any of these faults is reported on the first cycle where it diverges.

// File: rtl/qpr_pkg.sv
package qpr_pkg;

   typedef enum logic {
      RATE_FAST = 1'b0,
      RATE_SLOW = 1'b1
   } rate_e;

   function automatic int unsigned clamp_u(input int unsigned v,
                                           input int unsigned lo,
                                           input int unsigned hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

endpackage

// File: rtl/qpr_blank_sel.sv
module qpr_blank_sel #(
   parameter int unsigned HB_MIN      = 40,
   parameter int unsigned HB_MAX      = 200,
   parameter int unsigned HB_DEF      = 70,
   parameter int unsigned VB_MIN      = 20,
   parameter int unsigned VB_MAX      = 300,
   parameter int unsigned VB_DEF_FAST = 45,
   parameter int unsigned VB_DEF_SLOW = 270,
   parameter int unsigned HBW         = 8,
   parameter int unsigned VBW         = 9
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           rate_slow,
   input  logic           blank_prog,
   input  logic [HBW-1:0] hblank_cfg,
   input  logic [VBW-1:0] vblank_cfg,
   output logic [HBW-1:0] hb_q,
   output logic [VBW-1:0] vb_q
);
   import qpr_pkg::*;

   rate_e          rate;
   logic [HBW-1:0] hb_pick;
   logic [VBW-1:0] vb_pick;

   assign rate = rate_e'(rate_slow);

   always_comb begin
      if (blank_prog) begin
         hb_pick = HBW'(clamp_u(32'(hblank_cfg), HB_MIN, HB_MAX));
         vb_pick = VBW'(clamp_u(32'(vblank_cfg), VB_MIN, VB_MAX));
      end else begin
         hb_pick = HBW'(HB_DEF);
         vb_pick = (rate == RATE_SLOW) ? VBW'(VB_DEF_SLOW) : VBW'(VB_DEF_FAST);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hb_q <= HBW'(HB_DEF);
         vb_q <= VBW'(VB_DEF_FAST);
      end else if (load) begin
         hb_q <= hb_pick;
         vb_q <= vb_pick;
      end
   end

endmodule

// File: rtl/qpr_raster_cnt.sv
module qpr_raster_cnt #(
   parameter int unsigned ACT_GROUPS = 480,
   parameter int unsigned ACT_LINES  = 1080,
   parameter int unsigned HW         = 10,
   parameter int unsigned VW         = 11,
   parameter int unsigned HBW        = 8,
   parameter int unsigned VBW        = 9
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [HBW-1:0] hb,
   input  logic [VBW-1:0] vb,
   output logic           load,
   output logic [HW-1:0]  col,
   output logic [VW-1:0]  line,
   output logic           de,
   output logic           frame_start
);

   logic live_q;
   logic line_end;
   logic frame_end;

   assign line_end  = (32'(col) == ACT_GROUPS + 32'(hb) - 1);
   assign frame_end = line_end && (32'(line) == ACT_LINES + 32'(vb) - 1);
   assign load      = !live_q || frame_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         col    <= '0;
         line   <= '0;
      end else if (!live_q) begin
         live_q <= 1'b1;
      end else if (line_end) begin
         col  <= '0;
         line <= frame_end ? '0 : line + 1'b1;
      end else begin
         col <= col + 1'b1;
      end
   end

   assign de          = live_q && (32'(col) < ACT_GROUPS) && (32'(line) < ACT_LINES);
   assign frame_start = live_q && (col == '0) && (line == '0);

endmodule

// File: rtl/qpr_lane_map.sv
module qpr_lane_map #(
   parameter int unsigned LANES = 4,
   parameter int unsigned HW    = 10,
   parameter int unsigned IW    = 11
) (
   input  logic                de,
   input  logic [HW-1:0]       col,
   output logic [LANES*IW-1:0] lane_idx
);

   for (genvar p = 0; p < LANES; p++) begin : g_lane
      assign lane_idx[p*IW +: IW] = de ? IW'(32'(col) * LANES + 32'(p)) : '0;
   end

endmodule

// File: rtl/qpr_depth_fmt.sv
module qpr_depth_fmt #(
   parameter int unsigned LANES = 4,
   parameter int unsigned CW    = 10
) (
   input  logic                  de,
   input  logic                  depth10,
   input  logic [LANES*3*CW-1:0] px_in,
   output logic [LANES*3*CW-1:0] px_out
);
   localparam int unsigned PW   = 3 * CW;
   localparam int unsigned DROP = CW - 8;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      for (genvar c = 0; c < 3; c++) begin : g_col
         localparam int unsigned B = l * PW + c * CW;
         if (DROP == 0) begin : g_pass
            assign px_out[B +: CW] = de ? px_in[B +: CW] : '0;
         end else begin : g_trim
            assign px_out[B +: CW] = !de     ? '0 :
                                     depth10 ? px_in[B +: CW] :
                                     {px_in[B+DROP +: CW-DROP], {DROP{1'b0}}};
         end
      end
   end

endmodule

// File: rtl/qpix_raster_gen.sv
module qpix_raster_gen #(
   parameter int unsigned ACT_GROUPS  = 480,
   parameter int unsigned ACT_LINES   = 1080,
   parameter int unsigned LANES       = 4,
   parameter int unsigned CW          = 10,
   parameter int unsigned HB_MIN      = 40,
   parameter int unsigned HB_MAX      = 200,
   parameter int unsigned HB_DEF      = 70,
   parameter int unsigned VB_MIN      = 20,
   parameter int unsigned VB_MAX      = 300,
   parameter int unsigned VB_DEF_FAST = 45,
   parameter int unsigned VB_DEF_SLOW = 270,
   localparam int unsigned HW  = $clog2(ACT_GROUPS + HB_MAX),
   localparam int unsigned VW  = $clog2(ACT_LINES + VB_MAX),
   localparam int unsigned HBW = $clog2(HB_MAX + 1),
   localparam int unsigned VBW = $clog2(VB_MAX + 1),
   localparam int unsigned IW  = $clog2(ACT_GROUPS * LANES),
   localparam int unsigned PW  = 3 * CW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rate_slow,
   input  logic                depth10,
   input  logic                blank_prog,
   input  logic [HBW-1:0]      hblank_cfg,
   input  logic [VBW-1:0]      vblank_cfg,
   input  logic [LANES*PW-1:0] lane_px_in,
   output logic                de,
   output logic                frame_start,
   output logic [HW-1:0]       col,
   output logic [VW-1:0]       line,
   output logic [LANES*IW-1:0] lane_idx,
   output logic [LANES*PW-1:0] lane_px_out
);

   if (CW < 8) begin : g_bad_cw
      $error("qpix_raster_gen: CW must be at least 8");
   end
   if (HB_DEF < HB_MIN || HB_DEF > HB_MAX || HB_MIN > HB_MAX) begin : g_bad_hb
      $error("qpix_raster_gen: horizontal blanking limits inconsistent");
   end
   if (VB_DEF_FAST < VB_MIN || VB_DEF_FAST > VB_MAX ||
       VB_DEF_SLOW < VB_MIN || VB_DEF_SLOW > VB_MAX) begin : g_bad_vb
      $error("qpix_raster_gen: vertical blanking defaults out of range");
   end
   if (ACT_GROUPS == 0 || ACT_LINES == 0 || LANES == 0) begin : g_bad_geo
      $error("qpix_raster_gen: active geometry must be non-zero");
   end

   logic           load;
   logic [HBW-1:0] hb_q;
   logic [VBW-1:0] vb_q;

   qpr_blank_sel #(
      .HB_MIN(HB_MIN), .HB_MAX(HB_MAX), .HB_DEF(HB_DEF),
      .VB_MIN(VB_MIN), .VB_MAX(VB_MAX),
      .VB_DEF_FAST(VB_DEF_FAST), .VB_DEF_SLOW(VB_DEF_SLOW),
      .HBW(HBW), .VBW(VBW)
   ) u_sel (
      .clk(clk), .rst_n(rst_n), .load(load),
      .rate_slow(rate_slow), .blank_prog(blank_prog),
      .hblank_cfg(hblank_cfg), .vblank_cfg(vblank_cfg),
      .hb_q(hb_q), .vb_q(vb_q)
   );

   qpr_raster_cnt #(
      .ACT_GROUPS(ACT_GROUPS), .ACT_LINES(ACT_LINES),
      .HW(HW), .VW(VW), .HBW(HBW), .VBW(VBW)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .hb(hb_q), .vb(vb_q),
      .load(load), .col(col), .line(line),
      .de(de), .frame_start(frame_start)
   );

   qpr_lane_map #(.LANES(LANES), .HW(HW), .IW(IW)) u_map (
      .de(de), .col(col), .lane_idx(lane_idx)
   );

   qpr_depth_fmt #(.LANES(LANES), .CW(CW)) u_fmt (
      .de(de), .depth10(depth10), .px_in(lane_px_in), .px_out(lane_px_out)
   );

endmodule

// File: rtl/qpr_raster_chk.sv
module qpr_raster_chk #(
   parameter int unsigned ACT_LINES = 1080,
   parameter int unsigned LANES     = 4,
   parameter int unsigned CW        = 10,
   parameter int unsigned HW        = 10,
   parameter int unsigned VW        = 11,
   parameter int unsigned IW        = 11
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  depth10,
   input logic                  de,
   input logic                  frame_start,
   input logic [HW-1:0]         col,
   input logic [VW-1:0]         line,
   input logic [LANES*IW-1:0]   lane_idx,
   input logic [LANES*3*CW-1:0] lane_px_out
);
   localparam int unsigned DROP = CW - 8;

   p_fs_at_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (de && col == '0 && line == '0));

   p_fs_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);

   p_no_de_vblank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(line) >= ACT_LINES) |-> !de);

   p_col_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (col != '0) |-> (col == HW'($past(col) + 1'b1)));

   p_line_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (col == '0 && line != '0) |-> (line == VW'($past(line) + 1'b1)));

   p_idx_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !de |-> (lane_idx == '0));

   p_px_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !de |-> (lane_px_out == '0));

   if (DROP > 0) begin : g_lsb
      for (genvar k = 0; k < LANES * 3; k++) begin : g_word
         p_lsb_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (de && !depth10) |-> (lane_px_out[k*CW +: DROP] == '0));
      end
   end

endmodule

bind qpix_raster_gen qpr_raster_chk #(
   .ACT_LINES(ACT_LINES), .LANES(LANES), .CW(CW),
   .HW(HW), .VW(VW), .IW(IW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .depth10(depth10), .de(de),
   .frame_start(frame_start), .col(col), .line(line),
   .lane_idx(lane_idx), .lane_px_out(lane_px_out)
);

// File: tb/tb_qpix_raster_gen.sv
module tb_qpix_raster_gen;
   localparam int AG = 8, AL = 6, LN = 4, CW = 10;
   localparam int HMIN = 2, HMAX = 10, HDEF = 3;
   localparam int VMIN = 1, VMAX = 12, VFAST = 2, VSLOW = 5;
   localparam int HW = $clog2(AG + HMAX), VW = $clog2(AL + VMAX);
   localparam int HBW = $clog2(HMAX + 1), VBW = $clog2(VMAX + 1);
   localparam int IW = $clog2(AG * LN), PW = 3 * CW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic rate_slow = 1'b0, depth10 = 1'b1, blank_prog = 1'b0;
   logic [HBW-1:0] hblank_cfg = '0;
   logic [VBW-1:0] vblank_cfg = '0;
   logic [LN*PW-1:0] lane_px_in = '0;
   logic de, frame_start;
   logic [HW-1:0] col;
   logic [VW-1:0] line;
   logic [LN*IW-1:0] lane_idx;
   logic [LN*PW-1:0] lane_px_out;

   always #2.5 clk = ~clk;

   qpix_raster_gen #(
      .ACT_GROUPS(AG), .ACT_LINES(AL), .LANES(LN), .CW(CW),
      .HB_MIN(HMIN), .HB_MAX(HMAX), .HB_DEF(HDEF),
      .VB_MIN(VMIN), .VB_MAX(VMAX), .VB_DEF_FAST(VFAST), .VB_DEF_SLOW(VSLOW)
   ) dut (.*);

   typedef struct {
      logic de; logic fs; int col; int line;
      logic [LN*IW-1:0] idx; logic [LN*PW-1:0] px;
   } exp_t;
   exp_t q[$];

   int n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit done = 0;

   task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic int clampi(int v, int lo, int hi);
      return (v < lo) ? lo : (v > hi) ? hi : v;
   endfunction

   // model state, built from the requirements
   bit m_live = 0;
   int m_col = 0, m_line = 0, m_hb = HDEF, m_vb = VFAST;

   task automatic m_load();
      if (blank_prog) begin                      // R5
         m_hb = clampi(int'(hblank_cfg), HMIN, HMAX);
         m_vb = clampi(int'(vblank_cfg), VMIN, VMAX);
      end else begin                             // R4
         m_hb = HDEF;
         m_vb = rate_slow ? VSLOW : VFAST;
      end
   endtask

   // driver side: predict each cycle and push the expected outputs
   always @(posedge clk) begin
      exp_t e;
      #1;
      if (!rst_n) begin
         m_live = 0; m_col = 0; m_line = 0;
      end else if (!m_live) begin
         m_live = 1; m_load();
      end else if (m_col == AG + m_hb - 1) begin
         m_col = 0;
         if (m_line == AL + m_vb - 1) begin m_line = 0; m_load(); end   // R6
         else m_line++;
      end else m_col++;
      e.de   = m_live && m_col < AG && m_line < AL;
      e.fs   = e.de && m_col == 0 && m_line == 0;
      e.col  = m_col;
      e.line = m_line;
      e.idx  = '0;
      e.px   = '0;
      for (int p = 0; p < LN; p++)
         if (e.de) e.idx[p*IW +: IW] = IW'(m_col * LN + p);            // R8
      for (int k = 0; k < LN * 3; k++) begin
         logic [CW-1:0] w;
         w = lane_px_in[k*CW +: CW];
         if (!depth10) w[1:0] = 2'b00;                                 // R9
         if (e.de) e.px[k*CW +: CW] = w;
      end
      q.push_back(e);
   end

   // monitor: pop and compare away from the active edge
   always @(negedge clk) begin
      if (!done && q.size() > 0) begin
         exp_t e;
         string rde, rfs;
         e = q.pop_front();
         rde = rst_n ? {"R3/", cur_req} : "R1";
         rfs = rst_n ? {"R7/", cur_req} : "R1";
         chk(rde, 128'(de), 128'(e.de));
         chk(rfs, 128'(frame_start), 128'(e.fs));
         chk(rst_n ? {"R2/", cur_req} : "R1", 128'(col), 128'(e.col));
         chk(rst_n ? {"R3/", cur_req} : "R1", 128'(line), 128'(e.line));
         chk(rst_n ? {"R8/", cur_req} : "R1", 128'(lane_idx), 128'(e.idx));
         chk(rst_n ? {"R9/", cur_req} : "R1", 128'(lane_px_out), 128'(e.px));
      end
   end

   task automatic run(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         lane_px_in = (LN*PW)'({$urandom(), $urandom(), $urandom(), $urandom()});
      end
   endtask

   initial begin
      run(4);                                   // R1: reset held
      rst_n = 1'b1;
      cur_req = "R4"; run(2 * (AG + HDEF) * (AL + VFAST) + 5);
      rate_slow = 1'b1; depth10 = 1'b0;
      run(2 * (AG + HDEF) * (AL + VSLOW));
      cur_req = "R5"; blank_prog = 1'b1; hblank_cfg = 6; vblank_cfg = 4; depth10 = 1'b1;
      run(2 * (AG + HMAX) * (AL + VMAX));
      hblank_cfg = 1; vblank_cfg = 0;           // clamp low
      run(2 * (AG + HMAX) * (AL + VMAX));
      hblank_cfg = 15; vblank_cfg = 15; depth10 = 1'b0;   // clamp high
      run(2 * (AG + HMAX) * (AL + VMAX));
      cur_req = "R6"; hblank_cfg = 4; vblank_cfg = 3;
      run(37);
      hblank_cfg = 9; vblank_cfg = 7;           // mid-frame change
      run(53);
      blank_prog = 1'b0; rate_slow = 1'b0;
      run(3 * (AG + HMAX) * (AL + VMAX));
      cur_req = "R1"; rst_n = 1'b0;             // reset again mid-run
      run(3);
      rst_n = 1'b1;
      run(2 * (AG + HDEF) * (AL + VFAST));
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule